// File: doc/BRIEF.md
# Receive Error Status Latching Unit

This block sits between a serial receiver front end and the host side of a small receive buffer. Each incoming character arrives with two error flags: parity and framing. The block stores the character and its flags together in a three-entry FIFO, so the error bits the host reads always belong to the character the host is about to read. If a character arrives while the FIFO is full, the newest stored entry is replaced and marked as overrun.

The host sees three things: a data value, a set of status bits, and an interrupt request that carries a vector code. Parity and overrun status are sticky. They accumulate over every character read since the last error-reset command, and the host clears them with a single-cycle error-reset strobe.

Two interrupt modes are supported. In every-character mode, each available character requests service. In first-character mode, only the first character after a reset or error reset requests service. Also in first-character mode, reading a character that carries an error freezes the receive path until the host issues an error reset. Any character with an error produces a vector distinct from the normal receive vector.

Top module: `rx_err_latch`

## Requirements
- R1: After reset, rx_avail, st_par, st_frm, st_ovr and irq_req are 0 and irq_vec is 2'b00.
- R2: Characters are delivered in arrival order, with up to 3 held. rx_avail is 1 and rd_dout shows the oldest held character whenever at least one is held and no hold (R10) is active. A one-cycle rd_strobe removes that character.
- R3: A character that arrives while 3 are held, with no effective read in the same cycle, replaces the most recently stored character and sets that entry's overrun flag. The two older entries are unchanged. A read and an arrival in the same cycle on a full FIFO cause no overrun.
- R4: st_par is the head character's parity flag OR-ed with the parity flags of every character read since the last error reset. st_ovr follows the same rule for overrun. st_frm is the head character's framing flag alone.
- R5: When the FIFO becomes empty after a read, rd_dout and st_frm keep the values of the last character read. st_par and st_ovr keep their sticky values.
- R6: A one-cycle err_reset clears the sticky parity and overrun status, the retained status bits of the last read character, and any hold, effective on the next cycle.
- R7: irq_vec is 2'b11 (special condition) when the available head character has any error flag set, or while a hold is active. Otherwise it is 2'b10 when a receive-character request is pending. Otherwise it is 2'b00. irq_req is 1 exactly when irq_vec is nonzero.
- R8: With first_only=0, a receive-character request is pending whenever a character is available.
- R9: With first_only=1, a receive-character request is pending only until the first character is read after reset or err_reset. err_reset rearms it.
- R10: With first_only=1, reading a character with any error flag set starts a hold. While the hold lasts, rd_dout and the status stay on that character, rx_avail is 0, further reads have no effect, and arrivals are still stored. err_reset ends the hold.
- R11: An rd_strobe while rx_avail is 0 removes nothing. The next arriving character is delivered normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| first_only | input | 1 | 1 selects first-character interrupt mode, 0 selects every-character mode |
| in_valid | input | 1 | One-cycle strobe: a received character is present |
| in_data | input | DATA_W | Received character |
| in_par_err | input | 1 | Parity error flag of the received character |
| in_frm_err | input | 1 | Framing error flag of the received character |
| rd_strobe | input | 1 | One-cycle host read of the data value |
| err_reset | input | 1 | One-cycle error-reset command |
| rd_dout | output | DATA_W | Data value shown to the host |
| rx_avail | output | 1 | A character is available to read |
| st_par | output | 1 | Parity status (sticky) |
| st_frm | output | 1 | Framing status of the shown character |
| st_ovr | output | 1 | Overrun status (sticky) |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 2 | Vector code: 00 none, 10 receive character, 11 special condition |

## Verification
On every cycle, the assertions check the following:
- the FIFO level never exceeds its depth;
- a hold keeps rx_avail low, the vector at special, and the shown data and framing status stable;
- err_reset clears the sticky flags and the hold;
- a read with nothing available leaves the level alone;
- the request line agrees with the vector.

Only the bench's scenarios can show the rest:
- arrival-order delivery;
- which entry an overrun replaces;
- the OR of sticky parity across a sequence of reads;
- first-character rearming.

The bench sweeps every combination of parity and framing flags over three stacked characters and computes the expected status arithmetically.

// File: rtl/rx_err_pkg.sv
package rx_err_pkg;

    // Per-character error flags carried alongside the data
    typedef struct packed {
        logic ovr;
        logic frm;
        logic par;
    } rx_err_t;

    typedef enum logic [1:0] {
        VEC_NONE    = 2'b00,
        VEC_RXCHAR  = 2'b10,
        VEC_SPECIAL = 2'b11
    } rx_vec_e;

endpackage

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
    import rx_err_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic [DATA_W-1:0]        push_data,
    input  logic                     push_par,
    input  logic                     push_frm,
    input  logic                     pop,
    output logic [DATA_W-1:0]        head_data,
    output rx_err_t                  head_err,
    output logic                     not_empty,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] data;
        rx_err_t [DEPTH-1:0]          err;
        logic [PW-1:0]                wr;
        logic [PW-1:0]                rd;
        logic [CW-1:0]                cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        logic          full_drop;
        logic [PW-1:0] newest;
        st_d      = st_q;
        full_drop = push && (st_q.cnt == FULL_CNT) && !pop;
        newest    = (st_q.wr == '0) ? LAST_IDX : st_q.wr - PW'(1);
        if (full_drop) begin
            st_d.data[newest] = push_data;
            st_d.err[newest]  = '{ovr: 1'b1, frm: push_frm, par: push_par};
        end else if (push) begin
            st_d.data[st_q.wr] = push_data;
            st_d.err[st_q.wr]  = '{ovr: 1'b0, frm: push_frm, par: push_par};
            st_d.wr            = next_ptr(st_q.wr);
        end
        if (pop) begin
            st_d.rd = next_ptr(st_q.rd);
        end
        st_d.cnt = st_q.cnt + CW'(push && !full_drop) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_data = st_q.data[st_q.rd];
    assign head_err  = st_q.err[st_q.rd];
    assign not_empty = (st_q.cnt != '0);
    assign level     = st_q.cnt;

endmodule

// File: rtl/rx_err_stat.sv
module rx_err_stat
    import rx_err_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              first_only,
    input  logic              rd_strobe,
    input  logic              err_reset,
    input  logic              not_empty,
    input  logic [DATA_W-1:0] head_data,
    input  rx_err_t           head_err,
    output logic              pop,
    output logic [DATA_W-1:0] rd_dout,
    output logic              rx_avail,
    output logic              st_par,
    output logic              st_frm,
    output logic              st_ovr,
    output logic              irq_req,
    output logic [1:0]        irq_vec,
    output logic              hold_flag,
    output logic              stk_par,
    output logic              stk_ovr
);
    typedef struct packed {
        logic              par_stk;
        logic              ovr_stk;
        logic              hold;
        logic              armed;
        logic [DATA_W-1:0] last_data;
        rx_err_t           last_err;
    } stat_st_t;

    stat_st_t st_d, st_q;
    rx_err_t  cur_err;
    logic     head_bad;
    logic     special;
    logic     rx_pend;
    rx_vec_e  vec;

    always_comb begin
        rx_avail = not_empty && !st_q.hold;
        pop      = rd_strobe && rx_avail;
        head_bad = |head_err;
        cur_err  = rx_avail ? head_err  : st_q.last_err;
        rd_dout  = rx_avail ? head_data : st_q.last_data;

        st_d = st_q;
        if (pop) begin
            st_d.last_data = head_data;
            st_d.last_err  = head_err;
            st_d.par_stk   = st_q.par_stk | head_err.par;
            st_d.ovr_stk   = st_q.ovr_stk | head_err.ovr;
            if (first_only) begin
                st_d.armed = 1'b0;
                if (head_bad) st_d.hold = 1'b1;
            end
        end
        if (err_reset) begin
            st_d.par_stk  = 1'b0;
            st_d.ovr_stk  = 1'b0;
            st_d.hold     = 1'b0;
            st_d.armed    = 1'b1;
            st_d.last_err = '0;
        end

        special = st_q.hold || (rx_avail && head_bad);
        rx_pend = rx_avail && (!first_only || st_q.armed);
        if (special)      vec = VEC_SPECIAL;
        else if (rx_pend) vec = VEC_RXCHAR;
        else              vec = VEC_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.armed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign st_par    = st_q.par_stk | cur_err.par;
    assign st_ovr    = st_q.ovr_stk | cur_err.ovr;
    assign st_frm    = cur_err.frm;
    assign irq_req   = special || rx_pend;
    assign irq_vec   = vec;
    assign hold_flag = st_q.hold;
    assign stk_par   = st_q.par_stk;
    assign stk_ovr   = st_q.ovr_stk;

endmodule

// File: rtl/rx_err_latch.sv
module rx_err_latch
    import rx_err_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              first_only,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_par_err,
    input  logic              in_frm_err,
    input  logic              rd_strobe,
    input  logic              err_reset,
    output logic [DATA_W-1:0] rd_dout,
    output logic              rx_avail,
    output logic              st_par,
    output logic              st_frm,
    output logic              st_ovr,
    output logic              irq_req,
    output logic [1:0]        irq_vec
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] head_data;
    rx_err_t           head_err;
    logic              not_empty;
    logic              pop;
    logic [CW-1:0]     fifo_level;
    logic              hold_flag;
    logic              stk_par;
    logic              stk_ovr;

    rx_err_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (in_valid),
        .push_data (in_data),
        .push_par  (in_par_err),
        .push_frm  (in_frm_err),
        .pop       (pop),
        .head_data (head_data),
        .head_err  (head_err),
        .not_empty (not_empty),
        .level     (fifo_level)
    );

    rx_err_stat #(.DATA_W(DATA_W)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .first_only (first_only),
        .rd_strobe  (rd_strobe),
        .err_reset  (err_reset),
        .not_empty  (not_empty),
        .head_data  (head_data),
        .head_err   (head_err),
        .pop        (pop),
        .rd_dout    (rd_dout),
        .rx_avail   (rx_avail),
        .st_par     (st_par),
        .st_frm     (st_frm),
        .st_ovr     (st_ovr),
        .irq_req    (irq_req),
        .irq_vec    (irq_vec),
        .hold_flag  (hold_flag),
        .stk_par    (stk_par),
        .stk_ovr    (stk_ovr)
    );

endmodule

// File: rtl/rx_err_latch_chk.sv
module rx_err_latch_chk #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic                       rd_strobe,
    input logic                       err_reset,
    input logic [DATA_W-1:0]          rd_dout,
    input logic                       rx_avail,
    input logic                       st_frm,
    input logic                       irq_req,
    input logic [1:0]                 irq_vec,
    input logic [$clog2(DEPTH+1)-1:0] fifo_level,
    input logic                       hold_flag,
    input logic                       stk_par,
    input logic                       stk_ovr
);
    localparam int CW = $clog2(DEPTH + 1);

    // R2
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= CW'(DEPTH));

    // R10
    hold_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_flag |-> (!rx_avail && irq_vec == 2'b11));

    // R10
    hold_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_flag && !err_reset) |=> (hold_flag && $stable(rd_dout) && $stable(st_frm)));

    // R6
    reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_reset |=> (!stk_par && !stk_ovr && !hold_flag));

    // R11
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !rx_avail && !in_valid) |=> $stable(fifo_level));

    // R7
    vec_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == (irq_vec != 2'b00));

endmodule

bind rx_err_latch rx_err_latch_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .rd_strobe  (rd_strobe),
    .err_reset  (err_reset),
    .rd_dout    (rd_dout),
    .rx_avail   (rx_avail),
    .st_frm     (st_frm),
    .irq_req    (irq_req),
    .irq_vec    (irq_vec),
    .fifo_level (fifo_level),
    .hold_flag  (hold_flag),
    .stk_par    (stk_par),
    .stk_ovr    (stk_ovr)
);

// File: tb/rx_err_latch_tb.sv
`timescale 1ns/1ps
module rx_err_latch_tb;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          first_only = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_par_err = 1'b0;
    logic          in_frm_err = 1'b0;
    logic          rd_strobe = 1'b0;
    logic          err_reset = 1'b0;
    logic [DW-1:0] rd_dout;
    logic          rx_avail, st_par, st_frm, st_ovr, irq_req;
    logic [1:0]    irq_vec;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    rx_err_latch #(.DATA_W(DW), .DEPTH(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .first_only(first_only),
        .in_valid(in_valid), .in_data(in_data), .in_par_err(in_par_err),
        .in_frm_err(in_frm_err), .rd_strobe(rd_strobe), .err_reset(err_reset),
        .rd_dout(rd_dout), .rx_avail(rx_avail), .st_par(st_par), .st_frm(st_frm),
        .st_ovr(st_ovr), .irq_req(irq_req), .irq_vec(irq_vec)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
        in_valid = 1'b0; rd_strobe = 1'b0; err_reset = 1'b0;
    endtask

    task automatic push(input logic [DW-1:0] d, input logic p, input logic f);
        in_valid = 1'b1; in_data = d; in_par_err = p; in_frm_err = f;
        step();
    endtask

    task automatic rd();
        rd_strobe = 1'b1;
        step();
    endtask

    task automatic erst();
        err_reset = 1'b1;
        step();
    endtask

    // Full observation of the host-visible state
    task automatic look(input string tag, input int av, input int d, input int p,
                        input int f, input int o, input int v);
        chk({tag, " avail"}, rx_avail, av);
        if (d >= 0) chk({tag, " dout"}, rd_dout, d);
        chk({tag, " par"}, st_par, p);
        chk({tag, " frm"}, st_frm, f);
        chk({tag, " ovr"}, st_ovr, o);
        chk({tag, " vec"}, irq_vec, v);
        chk({tag, " irq"}, irq_req, (v != 0) ? 1 : 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        // R1 reset state
        look("R1", 0, -1, 0, 0, 0, 0);

        // R2 R4 R5 R6 R7 R8: sweep all parity/framing patterns of 3 characters
        first_only = 1'b0;
        for (int pat = 0; pat < 64; pat++) begin
            int sp;
            int last_f;
            sp = 0;
            last_f = 0;
            erst();
            for (int i = 0; i < 3; i++)
                push(DW'(pat * 3 + i), pat[2*i], pat[2*i+1]);
            for (int i = 0; i < 3; i++) begin
                int p, f;
                p = pat[2*i];
                f = pat[2*i+1];
                look("R2_R4_R7_R8 sweep", 1, (pat * 3 + i) % 256, sp | p, f, 0,
                     (p | f) ? 3 : 2);
                rd();
                sp = sp | p;
                last_f = f;
            end
            look("R5 sweep empty", 0, (pat * 3 + 2) % 256, sp, last_f, 0, 0);
            erst();
            look("R6 sweep cleared", 0, -1, 0, 0, 0, 0);
        end

        // R3 overrun replaces newest entry
        erst();
        push(8'hA1, 0, 0); push(8'hB2, 0, 0); push(8'hC3, 0, 0); push(8'hD4, 0, 0);
        look("R3 head A", 1, 'hA1, 0, 0, 0, 2);
        rd();
        look("R3 head B", 1, 'hB2, 0, 0, 0, 2);
        rd();
        look("R3 newest replaced", 1, 'hD4, 0, 0, 1, 3);
        rd();
        look("R3 R5 empty sticky ovr", 0, 'hD4, 0, 0, 1, 0);
        push(8'h11, 0, 0);
        look("R4 ovr sticky clean head", 1, 'h11, 0, 0, 1, 2);
        rd();
        erst();
        look("R6 ovr cleared", 0, -1, 0, 0, 0, 0);

        // R3 full with simultaneous read and arrival: no overrun
        push(8'h21, 0, 0); push(8'h22, 0, 0); push(8'h23, 0, 0);
        in_valid = 1'b1; in_data = 8'h24; in_par_err = 0; in_frm_err = 0;
        rd_strobe = 1'b1;
        step();
        look("R3 swap B", 1, 'h22, 0, 0, 0, 2); rd();
        look("R3 swap C", 1, 'h23, 0, 0, 0, 2); rd();
        look("R3 swap E", 1, 'h24, 0, 0, 0, 2); rd();
        look("R3 swap empty", 0, 'h24, 0, 0, 0, 0);

        // R11 read while empty removes nothing
        rd();
        push(8'h5A, 0, 0);
        look("R11 after idle read", 1, 'h5A, 0, 0, 0, 2);
        rd();
        look("R11 empty again", 0, 'h5A, 0, 0, 0, 0);

        // R9 first-character mode
        first_only = 1'b1;
        erst();
        push(8'h31, 0, 0); push(8'h32, 0, 0);
        look("R9 armed", 1, 'h31, 0, 0, 0, 2);
        rd();
        look("R9 disarmed", 1, 'h32, 0, 0, 0, 0);
        erst();
        look("R9 rearmed", 1, 'h32, 0, 0, 0, 2);
        rd();

        // R10 hold on an erroneous character
        erst();
        push(8'h41, 1, 0); push(8'h42, 0, 0);
        look("R10 bad head", 1, 'h41, 1, 0, 0, 3);
        rd();
        look("R10 held", 0, 'h41, 1, 0, 0, 3);
        rd();
        push(8'h43, 0, 0);
        look("R10 read ignored", 0, 'h41, 1, 0, 0, 3);
        erst();
        look("R10 released", 1, 'h42, 0, 0, 0, 2);
        rd();
        look("R10 next", 1, 'h43, 0, 0, 0, 0);
        rd();
        look("R10 drained", 0, 'h43, 0, 0, 0, 0);

        // R10 framing also holds
        erst();
        push(8'h51, 0, 1);
        rd();
        look("R10 frm held", 0, 'h51, 0, 1, 0, 3);
        erst();
        look("R6 R10 frm cleared", 0, 'h51, 0, 0, 0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule